// File: doc/BRIEF.md
# Interrupt Redirection Controller Core

This block keeps one redirection entry per interrupt input pin and turns pin activity into delivery requests. Each entry names a vector, a delivery mode, a destination and destination mode, an input polarity, a trigger type and a mask. The core keeps two bits of state per pin: a pending flag and an in-service flag. The in-service flag is used only by level-triggered pins. Whenever a pin is eligible, the core raises a delivery request that carries the fields of that pin's entry. The request uses a valid/ready handshake. A downstream agent owns destination resolution and the processor side, and it takes the request by asserting `dlv_ready`.

Software reaches the block through three word registers. Each sits at a 16-byte aligned offset. A select register picks an internal register. A data window reads or writes whatever the select register picks. A strobe register acknowledges end-of-interrupt by vector. Only `reg_addr[7:4]` is decoded. Redirection entries are 64 bits wide and are written as two 32-bit halves.

Edge pins latch a rising edge of their polarity-corrected level and drop it once the request is accepted. Level pins follow their corrected level. After a level pin is accepted it cannot be delivered again until an end-of-interrupt for its vector arrives, or until software rewrites the low half of its entry.

Top module: `irq_redir_core`

## Requirements
- R1: After reset, every entry reads back with only its mask bit (bit 16 of the low half) set and all other bits zero. The select register and the identifier read zero, and `dlv_valid` is low.
- R2: A write at offset 0x00 stores `reg_wdata[7:0]` in the select register. While `reg_addr` is 0x00, `reg_rdata` shows the select register in bits 7:0.
- R3: With select 0x01, the window reads (NUM_PINS−1) in bits 23:16 and VERSION in bits 7:0. With the defaults this is 0x00170020. Window writes to select 0x01 change nothing.
- R4: With select 0x00, a window write stores `reg_wdata[27:24]` as a 4-bit identifier. Reads with select 0x00 or 0x02 return the identifier in bits 27:24 and zeros elsewhere.
- R5: Entry n is reached at select 0x10+2n (low half) and 0x11+2n (high half). The low half holds:
  - vector in bits 7:0
  - delivery mode in bits 10:8
  - destination mode in bit 11
  - polarity in bit 13
  - in-service in bit 14, which writes cannot set
  - trigger in bit 15 (1 = level)
  - mask in bit 16

  The high half holds the destination in bits 31:24. All other bits read zero. Selects past the last entry read zero and ignore writes.
- R6: A pin's effective level is `irq_in[n]` XOR the entry's polarity bit. With polarity 1, a low input counts as asserted.
- R7: For an edge pin, a 0→1 change of the effective level sets pending. The first negative clock edge after the input's sampling edge shows the request. Acceptance clears pending. A level held high gives no second delivery, but a new 0→1 change does.
- R8: A level pin requests while its effective level is asserted, it is unmasked and its in-service bit is clear. Acceptance sets in-service, which blocks further requests.
- R9: A write at offset 0x40 carrying vector V in bits 7:0 clears the in-service bit of every level entry whose vector is V. Such a pin requests again at once if it is still asserted and unmasked. Entries with other vectors keep their in-service bit.
- R10: A write to the low half of an entry clears its in-service bit. A pin that is pending and now eligible requests in the cycle right after the write.
- R11: A masked pin never requests. An edge pin that saw an edge while masked keeps it pending and requests once it is unmasked.
- R12: When several pins are eligible, the lowest-numbered one is requested, one per cycle. An unaccepted request stays up while `dlv_ready` is low.
- R13: The request outputs carry the selected pin's index, vector, delivery mode, destination mode, destination and trigger type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the register range; bits 7:4 decoded |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq_in | input | NUM_PINS | Interrupt input pins, synchronous to clk |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_pin | output | PIN_W | Index of the requesting pin |
| dlv_vector | output | 8 | Entry vector |
| dlv_mode | output | 3 | Entry delivery mode |
| dlv_dest_mode | output | 1 | Entry destination mode |
| dlv_dest | output | 8 | Entry destination |
| dlv_level | output | 1 | 1 when the entry is level-triggered |

## Verification
The embedded properties check the following on every cycle:
- A request never names a masked pin, or a level pin whose in-service bit is set.
- The arbiter's pick is an eligible pin with no eligible pin below it.
- An accepted level request sets in-service on the next cycle.
- An accepted edge request clears pending on the next cycle.

The directed scenarios cover what depends on software sequences: register readback and the ignored writes, polarity inversion, end-of-interrupt by matching and non-matching vectors, re-delivery after a low-half rewrite, delivery of an edge seen while masked, and the order in which simultaneous edges are handed out.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // One stored redirection entry: only the fields that carry state.
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;       // 1 = level
        logic       rirr;       // in-service, level pins only
        logic       pol;        // 1 = active low
        logic       dest_mode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } redir_ent_t;

    // Register blocks, decoded from reg_addr[7:4]
    localparam logic [3:0] BLK_SEL = 4'h0;
    localparam logic [3:0] BLK_WIN = 4'h1;
    localparam logic [3:0] BLK_EOI = 4'h4;

    // Select values for the window
    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [6:0] SEL_TBL_PAIR = 7'h08;  // 0x10 >> 1

    function automatic logic [31:0] ent_lo_word(input redir_ent_t e);
        return {15'b0, e.mask, e.trig, e.rirr, e.pol, 1'b0,
                e.dest_mode, e.dmode, e.vector};
    endfunction

    function automatic logic [31:0] ent_hi_word(input redir_ent_t e);
        return {e.dest, 24'b0};
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] req_i,
    output logic [NUM_PINS-1:0] grant_o,
    output logic [PIN_W-1:0]    idx_o,
    output logic                any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = PIN_W'(i);
        end
        grant_o = req_i & (~req_i + 1'b1);
        any_o   = |req_i;
    end

    // R12
    grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (req_i[idx_o] && grant_o[idx_o]));

    // R12
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & (grant_o - 1'b1)) == '0));

endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  redir_ent_t [NUM_PINS-1:0] tbl_i,
    input  logic                      fire_i,
    input  logic [7:0]                vec_i,
    output logic [NUM_PINS-1:0]       hit_o
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
        assign hit_o[g] = fire_i && tbl_i[g].trig && (tbl_i[g].vector == vec_i);
    end

endmodule

// File: rtl/irq_win_read.sv
module irq_win_read
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20
) (
    input  logic [3:0]                blk_i,
    input  logic [7:0]                sel_i,
    input  logic [3:0]                id_i,
    input  redir_ent_t [NUM_PINS-1:0] tbl_i,
    output logic [31:0]               rdata_o
);

    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    logic [31:0] win_d;

    always_comb begin
        win_d = '0;
        if (sel_i == SEL_ID || sel_i == SEL_ARB) begin
            win_d = {4'b0, id_i, 24'b0};
        end else if (sel_i == SEL_VER) begin
            win_d = {8'b0, LAST_PIN, 8'b0, VERSION};
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (sel_i[7:1] == SEL_TBL_PAIR + 7'(i)) begin
                    win_d = sel_i[0] ? ent_hi_word(tbl_i[i]) : ent_lo_word(tbl_i[i]);
                end
            end
        end
    end

    always_comb begin
        case (blk_i)
            BLK_SEL: rdata_o = {24'b0, sel_i};
            BLK_WIN: rdata_o = win_d;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_redir_core.sv
module irq_redir_core
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [PIN_W-1:0]    dlv_pin,
    output logic [7:0]          dlv_vector,
    output logic [2:0]          dlv_mode,
    output logic                dlv_dest_mode,
    output logic [7:0]          dlv_dest,
    output logic                dlv_level
);

    typedef struct packed {
        redir_ent_t [NUM_PINS-1:0] tbl;
        logic [NUM_PINS-1:0]       pend;
        logic [NUM_PINS-1:0]       prev;
        logic [7:0]                sel;
        logic [3:0]                id;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NUM_PINS-1:0] eff, rise, want, grant, eoi_hit;
    logic [PIN_W-1:0]    pick;
    logic                any_want;
    logic                wr_sel, wr_win, wr_eoi, accept;

    assign wr_sel = reg_wr && (reg_addr[7:4] == BLK_SEL);
    assign wr_win = reg_wr && (reg_addr[7:4] == BLK_WIN);
    assign wr_eoi = reg_wr && (reg_addr[7:4] == BLK_EOI);

    // Per-pin effective level, edge detect and eligibility
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            eff[i]  = irq_in[i] ^ st_q.tbl[i].pol;
            rise[i] = eff[i] && !st_q.prev[i];
            want[i] = st_q.pend[i] && !st_q.tbl[i].mask &&
                      (!st_q.tbl[i].trig || !st_q.tbl[i].rirr);
        end
    end

    irq_prio_pick #(.NUM_PINS(NUM_PINS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (want),
        .grant_o (grant),
        .idx_o   (pick),
        .any_o   (any_want)
    );

    irq_eoi_match #(.NUM_PINS(NUM_PINS)) u_eoi (
        .tbl_i  (st_q.tbl),
        .fire_i (wr_eoi),
        .vec_i  (reg_wdata[7:0]),
        .hit_o  (eoi_hit)
    );

    irq_win_read #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rd (
        .blk_i   (reg_addr[7:4]),
        .sel_i   (st_q.sel),
        .id_i    (st_q.id),
        .tbl_i   (st_q.tbl),
        .rdata_o (reg_rdata)
    );

    assign dlv_valid     = any_want;
    assign dlv_pin       = pick;
    assign dlv_vector    = st_q.tbl[pick].vector;
    assign dlv_mode      = st_q.tbl[pick].dmode;
    assign dlv_dest_mode = st_q.tbl[pick].dest_mode;
    assign dlv_dest      = st_q.tbl[pick].dest;
    assign dlv_level     = st_q.tbl[pick].trig;
    assign accept        = dlv_valid && dlv_ready;

    // Next-state
    always_comb begin
        st_d      = st_q;
        st_d.prev = eff;

        // pending: level follows input, edge latches until accepted
        for (int i = 0; i < NUM_PINS; i++) begin
            if (st_q.tbl[i].trig) begin
                st_d.pend[i] = eff[i];
            end else begin
                if (accept && grant[i]) st_d.pend[i] = 1'b0;
                if (rise[i])            st_d.pend[i] = 1'b1;
            end
        end

        // end-of-interrupt, then acceptance (acceptance wins on a tie)
        for (int i = 0; i < NUM_PINS; i++) begin
            if (eoi_hit[i]) st_d.tbl[i].rirr = 1'b0;
            if (accept && grant[i] && st_q.tbl[i].trig) st_d.tbl[i].rirr = 1'b1;
        end

        if (wr_sel) st_d.sel = reg_wdata[7:0];

        if (wr_win && st_q.sel == SEL_ID) st_d.id = reg_wdata[27:24];

        for (int i = 0; i < NUM_PINS; i++) begin
            if (wr_win && st_q.sel[7:1] == SEL_TBL_PAIR + 7'(i)) begin
                if (st_q.sel[0]) begin
                    st_d.tbl[i].dest = reg_wdata[31:24];
                end else begin
                    st_d.tbl[i].vector    = reg_wdata[7:0];
                    st_d.tbl[i].dmode     = reg_wdata[10:8];
                    st_d.tbl[i].dest_mode = reg_wdata[11];
                    st_d.tbl[i].pol       = reg_wdata[13];
                    st_d.tbl[i].trig      = reg_wdata[15];
                    st_d.tbl[i].mask      = reg_wdata[16];
                    st_d.tbl[i].rirr      = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) st_q.tbl[i].mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R11
    masked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !st_q.tbl[dlv_pin].mask);

    // R8
    rirr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_level) |-> !st_q.tbl[dlv_pin].rirr);

    // R8
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dlv_level && !wr_win) |=> st_q.tbl[$past(dlv_pin)].rirr);

    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dlv_level && !wr_win && !rise[dlv_pin])
            |=> !st_q.pend[$past(dlv_pin)]);

endmodule

// File: tb/sim_irq_redir_core.sv
`timescale 1ns/1ps
module sim_irq_redir_core;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_in = '0;
    logic        dlv_valid;
    logic        dlv_ready = 1'b0;
    logic [4:0]  dlv_pin;
    logic [7:0]  dlv_vector;
    logic [2:0]  dlv_mode;
    logic        dlv_dest_mode;
    logic [7:0]  dlv_dest;
    logic        dlv_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    irq_redir_core u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
        .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_dest_mode(dlv_dest_mode),
        .dlv_dest(dlv_dest), .dlv_level(dlv_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_win(input logic [7:0] sel, input logic [31:0] d);
        wr(8'h00, {24'b0, sel});
        wr(8'h10, d);
    endtask

    task automatic rd_win(input logic [7:0] sel, output logic [31:0] v);
        wr(8'h00, {24'b0, sel});
        reg_addr = 8'h10;
        #1 v = reg_rdata;
    endtask

    task automatic accept_one();
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_addr = 8'h00; #1;
        check("R1 select after reset", reg_rdata, 32'h0);
        check("R1 no request after reset", {31'b0, dlv_valid}, 32'h0);
        rd_win(8'h10, v);  check("R1 entry0 low", v, 32'h0001_0000);
        rd_win(8'h3E, v);  check("R1 entry23 low", v, 32'h0001_0000);
        rd_win(8'h3F, v);  check("R1 entry23 high", v, 32'h0);
        rd_win(8'h00, v);  check("R1 id after reset", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h00, 32'h0000_002B);
        reg_addr = 8'h00; #1;
        check("R2 select readback", reg_rdata, 32'h2B);
        rd_win(8'h01, v);  check("R3 version", v, 32'h0017_0020);
        wr_win(8'h01, 32'hFFFF_FFFF);
        rd_win(8'h01, v);  check("R3 version write ignored", v, 32'h0017_0020);
        wr_win(8'h00, 32'hFA5A_5A5A);
        rd_win(8'h00, v);  check("R4 id readback", v, 32'h0A00_0000);
        rd_win(8'h02, v);  check("R4 arb readback", v, 32'h0A00_0000);
        wr_win(8'h40, 32'h0000_1234);
        rd_win(8'h40, v);  check("R5 past-table select", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr_win(8'h16, 32'h0000_4933);   // pin 3: vec 0x33, mode 1, dm 1, rirr attempt
        wr_win(8'h17, 32'hABCD_EF12);
        rd_win(8'h16, v);  check("R5 low half, bit14 not writable", v, 32'h0000_0933);
        rd_win(8'h17, v);  check("R5 high half", v, 32'hAB00_0000);
        irq_in[3] = 1'b1;
        tick(1);
        check("R7 edge request", {31'b0, dlv_valid}, 32'h1);
        check("R13 pin/vector", {19'b0, dlv_pin, dlv_vector}, {19'b0, 5'd3, 8'h33});
        check("R13 mode/dm/dest/level",
              {19'b0, dlv_mode, dlv_dest_mode, dlv_dest, dlv_level},
              {19'b0, 3'd1, 1'b1, 8'hAB, 1'b0});
        tick(1);
        check("R12 request held without ready", {31'b0, dlv_valid}, 32'h1);
        accept_one();
        check("R7 pending cleared on accept", {31'b0, dlv_valid}, 32'h0);
        tick(2);
        check("R7 held level no redelivery", {31'b0, dlv_valid}, 32'h0);
        irq_in[3] = 1'b0; tick(1);
        irq_in[3] = 1'b1; tick(1);
        check("R7 new edge delivered", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd3});
        accept_one();
        irq_in[3] = 1'b0;
        wr_win(8'h16, 32'h0001_0933);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr_win(8'h1A, 32'h0000_A055);   // pin 5: level, active low, vec 0x55
        tick(1);
        check("R6 inverted polarity asserts", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd5});
        check("R8 level flag", {31'b0, dlv_level}, 32'h1);
        accept_one();
        check("R8 blocked after accept", {31'b0, dlv_valid}, 32'h0);
        rd_win(8'h1A, v);  check("R8 in-service set", v, 32'h0000_E055);
        wr(8'h40, 32'h0000_0099); tick(1);
        check("R9 other vector no effect", {31'b0, dlv_valid}, 32'h0);
        wr(8'h40, 32'h0000_0055);
        check("R9 eoi redelivers", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd5});
        accept_one();
        irq_in[5] = 1'b1; tick(1);
        wr(8'h40, 32'h0000_0055);
        check("R9 eoi with pin idle", {31'b0, dlv_valid}, 32'h0);
        rd_win(8'h1A, v);  check("R9 in-service cleared", v, 32'h0000_A055);
        irq_in[5] = 1'b0; tick(1);
        accept_one();
        check("R10 blocked before rewrite", {31'b0, dlv_valid}, 32'h0);
        wr_win(8'h1A, 32'h0000_A055);
        check("R10 low write clears in-service", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd5});
        wr_win(8'h1A, 32'h0001_A055);
        irq_in[5] = 1'b1;
        check("R11 masked level no request", {31'b0, dlv_valid}, 32'h0);
    endtask

    task automatic t_mask();
        wr_win(8'h1E, 32'h0001_0077);   // pin 7 edge, masked
        irq_in[7] = 1'b1; tick(1);
        irq_in[7] = 1'b0; tick(1);
        check("R11 masked edge no request", {31'b0, dlv_valid}, 32'h0);
        wr_win(8'h1E, 32'h0000_0077);
        check("R11 unmask delivers pending", {19'b0, dlv_valid, dlv_pin, dlv_vector},
              {19'b0, 1'b1, 5'd7, 8'h77});
        accept_one();
        check("R11 cleared after accept", {31'b0, dlv_valid}, 32'h0);
        wr_win(8'h1E, 32'h0001_0077);
    endtask

    task automatic t_prio();
        wr_win(8'h22, 32'h0000_0092);   // pin 9
        wr_win(8'h14, 32'h0000_0029);   // pin 2
        irq_in[9] = 1'b1; irq_in[2] = 1'b1;
        tick(1);
        check("R12 lowest pin first", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd2});
        tick(1);
        check("R12 still lowest while waiting", {27'b0, dlv_valid, dlv_pin}, {27'b0, 1'b1, 5'd2});
        accept_one();
        check("R12 next pin after accept", {19'b0, dlv_valid, dlv_pin, dlv_vector},
              {19'b0, 1'b1, 5'd9, 8'h92});
        accept_one();
        check("R12 all served", {31'b0, dlv_valid}, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_edge();
        t_level();
        t_mask();
        t_prio();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule